// File: doc/BRIEF.md
# Memory-Mapped Event Counter Bank

This block is a performance monitor for a protocol bridge. It watches two single-cycle activity strobes, one for inbound requests and one for outbound requests. It also has an internal event that is active on every clock. It counts them in a bank of wide counters, and software programs it through a small register window. Each counter is steered to one source by an 8-bit event code. Counting needs both a bank-wide run bit and that counter's own enable bit. Software can load any counter with a start value.

A counter sets a sticky status bit when it rolls over from all ones to zero. A mask register selects which status bits may raise the single level interrupt output. Software clears status by writing ones to a separate clear location. All accesses use one write strobe, a 13-bit byte offset and a 64-bit data path. Control registers use the low 32 bits and are zero-extended on reads. Counters are transferred whole, in a single 64-bit access. Reads are combinational from the offset.

Top module: `evmon_bank`

## Requirements
- R1: After reset all counters, the run bit, the counter enables, the event codes and the status bits read 0, the mask reads all ones (0xff for eight counters) and irq is low.
- R2: While bit 0 of the run register (offset 0x1c00) is 0, no counter changes except by a software write.
- R3: Bit n of the enable register (offset 0x1c04) must be 1 for counter n to count; a counter whose bit is 0 keeps its value.
- R4: Counter n takes its 8-bit event code from the select register at offset 0x1c80 + 4*(n div 4), in bits 8*(n mod 4)+7 down to 8*(n mod 4), and that register reads back what was written.
- R5: Code 0x78 counts every clock, 0x5c counts outbound request strobes, 0x40 counts inbound request strobes; every other code never counts.
- R6: Counter n is read and written as one 64-bit value at offset 0x1d00 + 8*n; a write in the same cycle as an increment wins, and the written value appears unchanged on the next read.
- R7: A counter that advances from all ones to zero sets status bit n, readable at offset 0x1c78.
- R8: irq is high exactly when some status bit n is 1 and mask bit n (offset 0x1c70, 1 = blocked) is 0.
- R9: Writing the clear location (offset 0x1c7c) clears each status bit whose data bit is 1 and leaves the others; a rollover in the same cycle keeps its bit set.
- R10: Offset 0x1cf0 reads the VERSION parameter, and writes to it have no effect.
- R11: An enabled counter under run advances by exactly one per clock in which its selected source is active.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_rx | input | 1 | Inbound request strobe, one cycle per request |
| ev_tx | input | 1 | Outbound request strobe, one cycle per request |
| wr_en | input | 1 | Write strobe for the register window |
| addr | input | 13 | Byte offset of the access |
| wdata | input | 64 | Write data; control registers use bits 31:0 |
| rdata | output | 64 | Read data for addr, combinational |
| irq | output | 1 | Level interrupt, unmasked rollover pending |

## Verification
The bench builds the block with eight 64-bit counters and a fixed version word. This gives two select registers with four lanes each. A sweep over all 256 event codes rotates the target counter across all eight counters and both select registers. It checks every lane placement and every known and unknown code against counts computed from the strobe patterns. Counter preloads close to all ones bring the full 64-bit rollover, status, masking and clear cases within a few clocks.

// File: rtl/evmon_pkg.sv
package evmon_pkg;
   localparam int ADDR_W = 13;
   localparam int BUS_W  = 64;
   localparam int REG_W  = 32;
   localparam int CODE_W = 8;
   localparam int NUM_SRC = 3;
   localparam int LANES  = REG_W / CODE_W;

   localparam logic [ADDR_W-1:0] OFS_RUN  = 13'h1c00;
   localparam logic [ADDR_W-1:0] OFS_ENA  = 13'h1c04;
   localparam logic [ADDR_W-1:0] OFS_MASK = 13'h1c70;
   localparam logic [ADDR_W-1:0] OFS_STAT = 13'h1c78;
   localparam logic [ADDR_W-1:0] OFS_ICLR = 13'h1c7c;
   localparam logic [ADDR_W-1:0] OFS_SEL  = 13'h1c80;
   localparam logic [ADDR_W-1:0] OFS_VER  = 13'h1cf0;
   localparam logic [ADDR_W-1:0] OFS_CNT  = 13'h1d00;

   typedef enum logic [1:0] {
      SRC_RX  = 2'd0,
      SRC_TX  = 2'd1,
      SRC_CYC = 2'd2
   } src_e;

   localparam logic [CODE_W-1:0] CODE_RX  = 8'h40;
   localparam logic [CODE_W-1:0] CODE_TX  = 8'h5c;
   localparam logic [CODE_W-1:0] CODE_CYC = 8'h78;

   // Map an event code onto the source vector; unknown codes never hit.
   function automatic logic code_hit(input logic [CODE_W-1:0] code,
                                     input logic [NUM_SRC-1:0] src);
      logic hit;
      case (code)
         CODE_RX:  hit = src[int'(SRC_RX)];
         CODE_TX:  hit = src[int'(SRC_TX)];
         CODE_CYC: hit = src[int'(SRC_CYC)];
         default:  hit = 1'b0;
      endcase
      return hit;
   endfunction
endpackage

// File: rtl/evmon_counter.sv
module evmon_counter
   import evmon_pkg::*;
#(
   parameter int CTR_W = 64
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 run,
   input  logic                 en,
   input  logic [CODE_W-1:0]    code,
   input  logic [NUM_SRC-1:0]   src,
   input  logic                 wr,
   input  logic [CTR_W-1:0]     wdata,
   output logic [CTR_W-1:0]     count,
   output logic                 wrap
);
   logic inc;

   assign inc  = run & en & code_hit(code, src);
   // A software load suppresses both the increment and the rollover flag.
   assign wrap = inc & ~wr & (&count);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count <= '0;
      end else if (wr) begin
         count <= wdata;
      end else if (inc) begin
         count <= count + CTR_W'(1);
      end
   end
endmodule

// File: rtl/evmon_regs.sv
module evmon_regs
   import evmon_pkg::*;
#(
   parameter int NUM_CTR = 8
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      wr_en,
   input  logic [ADDR_W-1:0]         addr,
   input  logic [REG_W-1:0]          wdata,
   input  logic [NUM_CTR-1:0]        wrap,
   output logic                      run_o,
   output logic [NUM_CTR-1:0]        en_o,
   output logic [NUM_CTR-1:0]        mask_o,
   output logic [NUM_CTR-1:0]        status_o,
   output logic [NUM_CTR*CODE_W-1:0] codes_o
);
   localparam int NUM_SEL = (NUM_CTR + LANES - 1) / LANES;

   logic                            run_q;
   logic [NUM_CTR-1:0]              en_q;
   logic [NUM_CTR-1:0]              mask_q;
   logic [NUM_CTR-1:0]              status_q;
   logic [NUM_CTR-1:0][CODE_W-1:0]  code_q;
   logic [NUM_CTR-1:0]              clr;

   assign clr = (wr_en && addr == OFS_ICLR) ? wdata[NUM_CTR-1:0] : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q    <= 1'b0;
         en_q     <= '0;
         mask_q   <= '1;
         status_q <= '0;
         code_q   <= '0;
      end else begin
         // Rollover set dominates a simultaneous clear.
         status_q <= (status_q & ~clr) | wrap;
         if (wr_en) begin
            if (addr == OFS_RUN)  run_q  <= wdata[0];
            if (addr == OFS_ENA)  en_q   <= wdata[NUM_CTR-1:0];
            if (addr == OFS_MASK) mask_q <= wdata[NUM_CTR-1:0];
            for (int k = 0; k < NUM_SEL; k++) begin
               if (addr == OFS_SEL + ADDR_W'(4 * k)) begin
                  for (int l = 0; l < LANES; l++) begin
                     if (k * LANES + l < NUM_CTR)
                        code_q[k*LANES+l] <= wdata[l*CODE_W +: CODE_W];
                  end
               end
            end
         end
      end
   end

   assign run_o    = run_q;
   assign en_o     = en_q;
   assign mask_o   = mask_q;
   assign status_o = status_q;
   assign codes_o  = code_q;
endmodule

// File: rtl/evmon_rdmux.sv
module evmon_rdmux
   import evmon_pkg::*;
#(
   parameter int          NUM_CTR = 8,
   parameter int          CTR_W   = 64,
   parameter logic [31:0] VERSION = 32'h0001_0200
) (
   input  logic [ADDR_W-1:0]         addr,
   input  logic                      run,
   input  logic [NUM_CTR-1:0]        en,
   input  logic [NUM_CTR-1:0]        mask,
   input  logic [NUM_CTR-1:0]        status,
   input  logic [NUM_CTR*CODE_W-1:0] codes,
   input  logic [NUM_CTR*CTR_W-1:0]  counts,
   output logic [BUS_W-1:0]          rdata
);
   localparam int NUM_SEL = (NUM_CTR + LANES - 1) / LANES;

   always_comb begin
      rdata = '0;
      case (addr)
         OFS_RUN:  rdata = BUS_W'(run);
         OFS_ENA:  rdata = BUS_W'(en);
         OFS_MASK: rdata = BUS_W'(mask);
         OFS_STAT: rdata = BUS_W'(status);
         OFS_VER:  rdata = BUS_W'(VERSION);
         default:  rdata = '0;
      endcase
      for (int k = 0; k < NUM_SEL; k++) begin
         if (addr == OFS_SEL + ADDR_W'(4 * k)) begin
            for (int l = 0; l < LANES; l++) begin
               if (k * LANES + l < NUM_CTR)
                  rdata[l*CODE_W +: CODE_W] = codes[(k*LANES+l)*CODE_W +: CODE_W];
            end
         end
      end
      for (int n = 0; n < NUM_CTR; n++) begin
         if (addr == OFS_CNT + ADDR_W'(8 * n))
            rdata = BUS_W'(counts[n*CTR_W +: CTR_W]);
      end
   end
endmodule

// File: rtl/evmon_bank.sv
module evmon_bank
   import evmon_pkg::*;
#(
   parameter int          NUM_CTR = 8,
   parameter int          CTR_W   = 64,
   parameter logic [31:0] VERSION = 32'h0001_0200
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 ev_rx,
   input  logic                 ev_tx,
   input  logic                 wr_en,
   input  logic [ADDR_W-1:0]    addr,
   input  logic [BUS_W-1:0]     wdata,
   output logic [BUS_W-1:0]     rdata,
   output logic                 irq
);
   if (NUM_CTR < 1 || NUM_CTR > 32) begin : g_bad_num
      $error("evmon_bank: NUM_CTR must lie in 1..32");
   end
   if (CTR_W < 2 || CTR_W > BUS_W) begin : g_bad_width
      $error("evmon_bank: CTR_W must lie in 2..64");
   end

   logic                      run_q;
   logic [NUM_CTR-1:0]        en_q;
   logic [NUM_CTR-1:0]        mask_q;
   logic [NUM_CTR-1:0]        status_q;
   logic [NUM_CTR*CODE_W-1:0] codes;
   logic [NUM_CTR*CTR_W-1:0]  cnt_flat;
   logic [NUM_CTR-1:0]        wrap_v;
   logic [NUM_CTR-1:0]        cnt_wr;
   logic [NUM_SRC-1:0]        src;

   always_comb begin
      src = '0;
      src[int'(SRC_RX)]  = ev_rx;
      src[int'(SRC_TX)]  = ev_tx;
      src[int'(SRC_CYC)] = 1'b1;
   end

   evmon_regs #(.NUM_CTR(NUM_CTR)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .addr     (addr),
      .wdata    (wdata[REG_W-1:0]),
      .wrap     (wrap_v),
      .run_o    (run_q),
      .en_o     (en_q),
      .mask_o   (mask_q),
      .status_o (status_q),
      .codes_o  (codes)
   );

   for (genvar n = 0; n < NUM_CTR; n++) begin : g_ctr
      localparam logic [ADDR_W-1:0] MY_OFS = OFS_CNT + ADDR_W'(8 * n);
      assign cnt_wr[n] = wr_en && (addr == MY_OFS);
      evmon_counter #(.CTR_W(CTR_W)) u_ctr (
         .clk   (clk),
         .rst_n (rst_n),
         .run   (run_q),
         .en    (en_q[n]),
         .code  (codes[n*CODE_W +: CODE_W]),
         .src   (src),
         .wr    (cnt_wr[n]),
         .wdata (wdata[CTR_W-1:0]),
         .count (cnt_flat[n*CTR_W +: CTR_W]),
         .wrap  (wrap_v[n])
      );
   end

   evmon_rdmux #(.NUM_CTR(NUM_CTR), .CTR_W(CTR_W), .VERSION(VERSION)) u_rd (
      .addr   (addr),
      .run    (run_q),
      .en     (en_q),
      .mask   (mask_q),
      .status (status_q),
      .codes  (codes),
      .counts (cnt_flat),
      .rdata  (rdata)
   );

   assign irq = |(status_q & ~mask_q);
endmodule

// File: rtl/evmon_chk.sv
module evmon_chk
   import evmon_pkg::*;
#(
   parameter int          NUM_CTR = 8,
   parameter int          CTR_W   = 64,
   parameter logic [31:0] VERSION = 32'h0001_0200
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic [ADDR_W-1:0]    addr,
   input  logic [BUS_W-1:0]     wdata,
   input  logic [BUS_W-1:0]     rdata,
   input  logic                 irq,
   input  logic                 run,
   input  logic [NUM_CTR-1:0]   mask,
   input  logic [NUM_CTR-1:0]   status,
   input  logic [NUM_CTR-1:0]   wrap,
   input  logic [CTR_W-1:0]     cnt0
);
   logic wr0;
   assign wr0 = wr_en && (addr == OFS_CNT);

   assert_reset_state_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (mask == '1 && status == '0 && !irq));

   assert_halt_when_stopped_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !wr0) |=> $stable(cnt0));

   assert_write_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
      wr0 |=> (cnt0 == $past(wdata[CTR_W-1:0])));

   assert_wrap_sets_status_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt0 == '1 && !wr0) ##1 (cnt0 == '0) |-> status[0]);

   assert_masked_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (mask == '1) |-> !irq);

   assert_irq_rise_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> (status != $past(status) || mask != $past(mask)));

   assert_clear_takes_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == OFS_ICLR && wrap == '0)
      |=> ((status & $past(wdata[NUM_CTR-1:0])) == '0));

   assert_version_fixed_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (addr == OFS_VER) |-> (rdata == BUS_W'(VERSION)));
endmodule

bind evmon_bank evmon_chk #(.NUM_CTR(NUM_CTR), .CTR_W(CTR_W), .VERSION(VERSION)) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .wr_en  (wr_en),
   .addr   (addr),
   .wdata  (wdata),
   .rdata  (rdata),
   .irq    (irq),
   .run    (run_q),
   .mask   (mask_q),
   .status (status_q),
   .wrap   (wrap_v),
   .cnt0   (cnt_flat[CTR_W-1:0])
);

// File: tb/sim_evmon_bank.sv
`timescale 1ns/1ps
module sim_evmon_bank;
   localparam logic [31:0] VER = 32'h0001_0200;
   localparam logic [12:0] A_RUN  = 13'h1c00;
   localparam logic [12:0] A_ENA  = 13'h1c04;
   localparam logic [12:0] A_MASK = 13'h1c70;
   localparam logic [12:0] A_STAT = 13'h1c78;
   localparam logic [12:0] A_CLR  = 13'h1c7c;
   localparam logic [12:0] A_SEL  = 13'h1c80;
   localparam logic [12:0] A_VER  = 13'h1cf0;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ev_rx = 1'b0, ev_tx = 1'b0, wr_en = 1'b0;
   logic [12:0] addr = '0;
   logic [63:0] wdata = '0;
   logic [63:0] rdata;
   logic        irq;
   int          n_chk = 0, n_fail = 0;
   logic [63:0] rv;

   always #2.5 clk = ~clk;

   evmon_bank #(.NUM_CTR(8), .CTR_W(64), .VERSION(VER)) u0 (
      .clk(clk), .rst_n(rst_n), .ev_rx(ev_rx), .ev_tx(ev_tx),
      .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq));

   function automatic logic [12:0] cofs(input int n);
      return 13'h1d00 + 13'(8 * n);
   endfunction

   task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   // All tasks start and end at a falling edge.
   task automatic wr(input logic [12:0] a, input logic [63:0] d);
      wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [12:0] a, output logic [63:0] d);
      addr = a;
      #0.5;
      d = rdata;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   // Run window: cycle source counts n+1, strobes count their pattern bits.
   task automatic window(input int n, input logic [15:0] rxp, input logic [15:0] txp);
      wr(A_RUN, 64'd1);
      for (int i = 0; i < n; i++) begin
         ev_rx = rxp[i]; ev_tx = txp[i];
         @(negedge clk);
      end
      ev_rx = 1'b0; ev_tx = 1'b0;
      wr(A_RUN, 64'd0);
   endtask

   function automatic logic [63:0] delta(input logic [7:0] code);
      case (code)
         8'h40:   return 64'd4;
         8'h5c:   return 64'd3;
         8'h78:   return 64'd7;
         default: return 64'd0;
      endcase
   endfunction

   initial begin
      #(5.0 * 150000);
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      idle(3);
      rst_n = 1'b1;
      idle(1);

      // R1: reset state
      rd(A_RUN, rv);  chk("R1 run", rv, 64'd0);
      rd(A_ENA, rv);  chk("R1 enable", rv, 64'd0);
      rd(A_MASK, rv); chk("R1 mask", rv, 64'hff);
      rd(A_STAT, rv); chk("R1 status", rv, 64'd0);
      rd(A_SEL, rv);  chk("R1 select0", rv, 64'd0);
      rd(A_SEL + 13'd4, rv); chk("R1 select1", rv, 64'd0);
      for (int n = 0; n < 8; n++) begin
         rd(cofs(n), rv); chk("R1 counter", rv, 64'd0);
      end
      chk("R1 irq", 64'(irq), 64'd0);

      // R10: version read and write ignored
      rd(A_VER, rv); chk("R10 version", rv, 64'(VER));
      wr(A_VER, 64'h0);
      rd(A_VER, rv); chk("R10 version after write", rv, 64'(VER));

      // R4 R5 R11: sweep of all event codes across counters and lanes
      for (int c = 0; c < 256; c++) begin
         int          ctr;
         logic [63:0] base;
         logic [12:0] sa;
         ctr  = c % 8;
         sa   = A_SEL + 13'(4 * (ctr / 4));
         base = 64'(c) * 64'h1_0000_0001;
         wr(A_SEL, 64'd0);
         wr(A_SEL + 13'd4, 64'd0);
         wr(sa, 64'(c) << (8 * (ctr % 4)));
         wr(A_ENA, 64'd1 << ctr);
         wr(cofs(ctr), base);
         rd(sa, rv); chk("R4 select readback", rv, 64'(c) << (8 * (ctr % 4)));
         window(6, 16'b101101, 16'b010011);
         rd(cofs(ctr), rv); chk("R5 R11 code count", rv, base + delta(8'(c)));
      end

      // R2: no counting while run is 0
      wr(A_SEL, 64'h7878_7878);
      wr(A_SEL + 13'd4, 64'h7878_7878);
      wr(A_ENA, 64'hff);
      wr(cofs(0), 64'd5);
      idle(10);
      rd(cofs(0), rv); chk("R2 halted", rv, 64'd5);

      // R3: only enabled counter advances
      wr(A_ENA, 64'h02);
      wr(cofs(0), 64'd100);
      wr(cofs(1), 64'd200);
      window(6, 16'h0, 16'h0);
      rd(cofs(0), rv); chk("R3 disabled counter", rv, 64'd100);
      rd(cofs(1), rv); chk("R3 enabled counter", rv, 64'd207);

      // R6: write wins over increment, full 64-bit access
      wr(A_ENA, 64'h04);
      wr(A_RUN, 64'd1);
      wr(cofs(2), 64'h1234);
      rd(cofs(2), rv); chk("R6 write wins", rv, 64'h1234);
      idle(1);
      rd(cofs(2), rv); chk("R6 counts after write", rv, 64'h1235);
      wr(A_RUN, 64'd0);
      wr(cofs(7), 64'hdead_beef_cafe_f00d);
      rd(cofs(7), rv); chk("R6 64-bit readback", rv, 64'hdead_beef_cafe_f00d);

      // R7 R8 R9: rollover, masking, clearing
      wr(A_ENA, 64'h08);
      wr(cofs(3), ~64'd2);
      wr(A_RUN, 64'd1);
      idle(3);
      rd(cofs(3), rv); chk("R7 rolled to zero", rv, 64'd0);
      rd(A_STAT, rv);  chk("R7 status set", rv, 64'h08);
      chk("R8 masked irq low", 64'(irq), 64'd0);
      wr(A_RUN, 64'd0);
      wr(A_MASK, 64'hf7);
      chk("R8 unmasked irq high", 64'(irq), 64'd1);
      wr(A_CLR, 64'h04);
      rd(A_STAT, rv); chk("R9 other bit kept", rv, 64'h08);
      chk("R9 irq still high", 64'(irq), 64'd1);
      wr(A_CLR, 64'h08);
      rd(A_STAT, rv); chk("R9 cleared", rv, 64'h00);
      chk("R8 irq low after clear", 64'(irq), 64'd0);

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule